// File: doc/BRIEF.md
# USB Subsystem Control Register with Clock-Domain Handshake

This block is the bus-facing control register of a USB subsystem. Software reaches it over a plain register bus (select, write strobe, byte address, write data, read data, error). It holds a PLL reference-speed select, an ID-source override (an enable bit and a value bit), a module enable bit and a software-reset bit. The block also drives a resolved ID signal, a module-enable signal and a subsystem-reset signal. The last two live in a slower core clock domain.

Changes to the enable bit and the software reset have to cross into the core domain. Each crossing uses a toggle request that passes through a two-flop synchronizer, and a toggle acknowledge that passes back the same way. A read-only sync-busy register reports which crossing is still pending. While a software reset runs, the register file refuses writes with a bus error and reads back its reset image. When the reset finishes, the subsystem is left disabled with every field cleared.

Top module: `usbctl_sync_reg`

## Requirements
- R1: After reset, the control register at offset 0x0 and the sync-busy register at offset 0x4 both read 0. The module-enable, subsystem-reset and reference-select outputs are all low.
- R2: The control register holds five fields, each read back in place: bit 10 selects the PLL reference speed (0 = 12 MHz, 1 = 24 MHz, driven on `pll_ref24_o`), bit 9 enables the ID override, bit 8 is the ID override value, bit 1 is ENABLE and bit 0 is the software reset. While ENABLE is 0, a write that does not start a reset stores bits 10, 9 and 8.
- R3: While the stored ENABLE bit is 1, writes do not change bits 10, 9 and 8. ENABLE itself stays writable.
- R4: When bit 9 is 0, `id_o` follows `phy_id`. When bit 9 is 1, `id_o` equals bit 8 (0 = A plug, 1 = B plug).
- R5: A write of ENABLE is visible on readback in the next cycle, and sync-busy bit 1 reads 1 at that point. That bit clears only after the core domain has taken the value, and at that time `core_en_o` equals the written value.
- R6: An ENABLE write made while sync-busy bit 1 is set is held back, not lost. After back-to-back writes have settled, `core_en_o` equals the last value written.
- R7: A write with bit 0 set starts a software reset and discards every other bit of that write. ENABLE does not reach the core, and the fields do not change. A write with bit 0 clear never starts a reset.
- R8: While a software reset is pending, writes return an error, the control register reads 0, the sync-busy register reads 0x1, `core_rst_o` is asserted and `core_en_o` is low.
- R9: When the software reset completes, both registers read 0 and `core_en_o` and `pll_ref24_o` are low.
- R10: While `wr_protect` is high, every write to the control register returns an error and changes no state.
- R11: Writes to offset 0x4 or to any unmapped offset return an error and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Error response for the current access |
| wr_protect | input | 1 | Blocks writes to the control register |
| phy_id | input | 1 | ID pin state reported by the PHY |
| id_o | output | 1 | Resolved ID |
| pll_ref24_o | output | 1 | 1 = 24 MHz reference, 0 = 12 MHz |
| core_clk | input | 1 | Core domain clock |
| core_rst_n | input | 1 | Active-low asynchronous reset, core domain |
| core_en_o | output | 1 | Module enable in the core domain |
| core_rst_o | output | 1 | Subsystem reset in the core domain |

## Verification
A lost or duplicated toggle on either side of the crossing shows up at the ports in one of two ways. Sync-busy either stays set indefinitely, or it clears while `core_en_o` disagrees with the readback. The bench waits a bounded number of polls for the busy bits, so a lost toggle is caught within a few hundred bus cycles. A wrong field latch or a broken protect gate is caught on the very next read, because every rejected or ignored write is followed by a readback. A reset that does not clear its state is caught by the first read after sync-busy returns to 0.

// File: rtl/usbctl_sync_reg.sv
`timescale 1ns/1ps
module usbctl_sync_reg #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              wr_protect,
  input  logic              phy_id,
  output logic              id_o,
  output logic              pll_ref24_o,
  input  logic              core_clk,
  input  logic              core_rst_n,
  output logic              core_en_o,
  output logic              core_rst_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(4);

  // bus domain state
  logic refsel_q, idoven_q, idval_q, en_q;
  logic en_pend_q, en_req_q, en_sent_q, sr_req_q;
  logic en_a1, en_a2, sr_a1, sr_a2;
  // core domain state
  logic c_en1, c_en2, c_en3, c_sr1, c_sr2, c_sr3;
  logic en_ack_q, sr_ack_q, core_en_q;
  logic [CW-1:0] rst_cnt;

  logic swrst_busy, en_busy, sr_done, wr_ok, launch;
  logic unused_bits;

  assign swrst_busy = sr_req_q != sr_a2;
  assign en_busy    = en_pend_q | (en_req_q != en_a2);
  assign sr_done    = sr_a1 != sr_a2;
  assign wr_ok      = bus_sel & bus_we & (bus_addr == A_CTRL) & ~swrst_busy & ~wr_protect;
  assign bus_err    = bus_sel & bus_we & ~wr_ok;
  assign launch     = en_pend_q & (en_req_q == en_a2) & ~swrst_busy;

  assign id_o        = idoven_q ? idval_q : phy_id;
  assign pll_ref24_o = refsel_q;
  assign core_en_o   = core_en_q;
  assign core_rst_o  = rst_cnt != '0;
  assign unused_bits = ^{bus_wdata[DATA_W-1:11], bus_wdata[7:2]};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == A_CTRL && !swrst_busy)
        bus_rdata = {{(DATA_W-11){1'b0}}, refsel_q, idoven_q, idval_q, 6'b0, en_q, 1'b0};
      else if (bus_addr == A_BUSY)
        bus_rdata = swrst_busy ? DATA_W'(1) : {{(DATA_W-2){1'b0}}, en_busy, 1'b0};
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      refsel_q <= 1'b0; idoven_q <= 1'b0; idval_q <= 1'b0; en_q <= 1'b0;
      en_pend_q <= 1'b0; en_req_q <= 1'b0; en_sent_q <= 1'b0; sr_req_q <= 1'b0;
      en_a1 <= 1'b0; en_a2 <= 1'b0; sr_a1 <= 1'b0; sr_a2 <= 1'b0;
    end else begin
      en_a1 <= en_ack_q;
      en_a2 <= en_a1;
      sr_a1 <= sr_ack_q;
      sr_a2 <= sr_a1;
      if (sr_done) begin
        refsel_q <= 1'b0; idoven_q <= 1'b0; idval_q <= 1'b0;
        en_q <= 1'b0; en_pend_q <= 1'b0;
      end else if (wr_ok) begin
        if (bus_wdata[0]) begin
          sr_req_q <= ~sr_req_q;
        end else begin
          en_q      <= bus_wdata[1];
          en_pend_q <= 1'b1;
          if (!en_q) begin
            refsel_q <= bus_wdata[10];
            idoven_q <= bus_wdata[9];
            idval_q  <= bus_wdata[8];
          end
        end
      end else if (launch) begin
        en_req_q  <= ~en_req_q;
        en_sent_q <= en_q;
        en_pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      c_en1 <= 1'b0; c_en2 <= 1'b0; c_en3 <= 1'b0;
      c_sr1 <= 1'b0; c_sr2 <= 1'b0; c_sr3 <= 1'b0;
      en_ack_q <= 1'b0; sr_ack_q <= 1'b0; core_en_q <= 1'b0;
      rst_cnt <= '0;
    end else begin
      c_en1 <= en_req_q;
      c_en2 <= c_en1;
      c_en3 <= c_en2;
      c_sr1 <= sr_req_q;
      c_sr2 <= c_sr1;
      c_sr3 <= c_sr2;
      en_ack_q <= c_en2;
      if (c_sr2 != c_sr3) begin
        rst_cnt   <= CW'(RST_CYCLES);
        core_en_q <= 1'b0;
      end else if (rst_cnt != '0) begin
        rst_cnt <= rst_cnt - CW'(1);
        if (rst_cnt == CW'(1)) sr_ack_q <= c_sr3;
      end else if (c_en2 != c_en3) begin
        core_en_q <= en_sent_q;
      end
    end
  end

  // R3
  enable_protect_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_ok && !bus_wdata[0] && en_q) |=> $stable({refsel_q, idoven_q, idval_q}));

  // R5
  busy_set_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_ok && !bus_wdata[0]) |=> en_busy);

  // R7
  swrst_prio_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_ok && bus_wdata[0]) |=> (swrst_busy && $stable({en_q, en_pend_q, refsel_q, idoven_q, idval_q})));

  // R9
  swrst_done_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $fell(swrst_busy) |-> !(en_q || en_pend_q || refsel_q || idoven_q || idval_q));

  // R10
  protect_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_sel && bus_we && wr_protect && !sr_done) |=>
      $stable({refsel_q, idoven_q, idval_q, en_q, sr_req_q}));

  // R8
  core_rst_disables_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    core_rst_o |-> !core_en_o);
endmodule

// File: tb/usbctl_sync_reg_test.sv
`timescale 1ns/1ps
module usbctl_sync_reg_test;
  logic bus_clk = 0, core_clk = 0, bus_rst_n = 0, core_rst_n = 0;
  logic bus_sel = 0, bus_we = 0, wr_protect = 0, phy_id = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err, id_o, pll_ref24_o, core_en_o, core_rst_o;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 bus_clk = ~bus_clk;
  always #6.5 core_clk = ~core_clk;

  usbctl_sync_reg uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .wr_protect(wr_protect), .phy_id(phy_id), .id_o(id_o), .pll_ref24_o(pll_ref24_o),
    .core_clk(core_clk), .core_rst_n(core_rst_n), .core_en_o(core_en_o), .core_rst_o(core_rst_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic err);
    @(negedge bus_clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1 err = bus_err;
    @(negedge bus_clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wait_idle(output bit ok, output bit saw_rst, output bit saw_en);
    logic [31:0] s;
    ok = 0; saw_rst = 0; saw_en = 0;
    for (int i = 0; i < 400; i++) begin
      rd(4'h4, s);
      if (core_rst_o) saw_rst = 1;
      if (core_en_o) saw_en = 1;
      if (s == 0) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    phy_id = 1;
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 busy", d, 0);
    chk("R1 outputs", {core_en_o, core_rst_o, pll_ref24_o}, 0);
    chk("R4 id from phy", id_o, 1);
  endtask

  task automatic t_fields;
    logic e; logic [31:0] d;
    phy_id = 0;
    wr(4'h0, 32'h700, e); chk("R2 err", e, 0);
    rd(4'h0, d); chk("R2 readback", d, 32'h700);
    chk("R2 pll select", pll_ref24_o, 1);
    chk("R4 override B", id_o, 1);
    wr(4'h0, 32'h200, e); #1 chk("R4 override A", id_o, 0);
    wr(4'h0, 32'h500, e); rd(4'h0, d); chk("R2 readback 2", d, 32'h500);
    phy_id = 1; #1 chk("R4 phy high", id_o, 1);
    phy_id = 0; #1 chk("R4 phy low", id_o, 0);
    wr(4'h0, 32'h700, e);
  endtask

  task automatic t_enable;
    logic e; logic [31:0] d; bit ok, sr, se;
    wr(4'h0, 32'h702, e);
    rd(4'h0, d); chk("R5 immediate", d, 32'h702);
    rd(4'h4, d); chk("R5 busy set", d, 32'h2);
    wait_idle(ok, sr, se); chk("R5 busy clears", ok, 1);
    chk("R5 core enable", core_en_o, 1);
  endtask

  task automatic t_protect;
    logic e; logic [31:0] d; bit ok, sr, se;
    wr(4'h0, 32'h002, e); rd(4'h0, d); chk("R3 fields held", d, 32'h702);
    wr(4'h0, 32'h000, e); rd(4'h0, d); chk("R3 disable keeps fields", d, 32'h700);
    wait_idle(ok, sr, se); chk("R5 idle", ok, 1);
    chk("R5 core disable", core_en_o, 0);
  endtask

  task automatic t_stall;
    logic e; logic [31:0] d; bit ok, sr, se;
    wr(4'h0, 32'h702, e); wr(4'h0, 32'h700, e); wr(4'h0, 32'h702, e);
    rd(4'h4, d); chk("R6 busy", d, 32'h2);
    wait_idle(ok, sr, se); chk("R6 idle", ok, 1);
    chk("R6 last value on", core_en_o, 1);
    wr(4'h0, 32'h700, e); wr(4'h0, 32'h702, e); wr(4'h0, 32'h700, e);
    wait_idle(ok, sr, se);
    chk("R6 last value off", core_en_o, 0);
  endtask

  task automatic t_wp;
    logic e; logic [31:0] d;
    wr_protect = 1;
    wr(4'h0, 32'h000, e); chk("R10 err", e, 1);
    rd(4'h0, d); chk("R10 unchanged", d, 32'h700);
    wr(4'h0, 32'h001, e); chk("R10 err swrst", e, 1);
    rd(4'h4, d); chk("R10 no reset", d, 0);
    wr_protect = 0;
  endtask

  task automatic t_badaddr;
    logic e; logic [31:0] d;
    wr(4'h4, 32'h3, e); chk("R11 busy reg write err", e, 1);
    wr(4'h8, 32'h0, e); chk("R11 unmapped err", e, 1);
    rd(4'h0, d); chk("R11 ctrl unchanged", d, 32'h700);
    rd(4'h4, d); chk("R11 busy unchanged", d, 0);
  endtask

  task automatic t_swrst;
    logic e; logic [31:0] d; bit ok, sr, se;
    wr(4'h0, 32'h702, e); wait_idle(ok, sr, se);
    chk("R5 enabled before reset", core_en_o, 1);
    wr(4'h0, 32'h001, e); chk("R8 start no err", e, 0);
    rd(4'h0, d); chk("R8 ctrl reads 0", d, 0);
    rd(4'h4, d); chk("R8 busy reads 1", d, 1);
    wr(4'h0, 32'h500, e); chk("R8 write err", e, 1);
    wait_idle(ok, sr, se); chk("R9 completes", ok, 1);
    chk("R8 core reset seen", sr, 1);
    rd(4'h0, d); chk("R9 ctrl cleared", d, 0);
    rd(4'h4, d); chk("R9 busy cleared", d, 0);
    chk("R9 outputs low", {core_en_o, pll_ref24_o}, 0);
  endtask

  task automatic t_prio;
    logic e; logic [31:0] d; bit ok, sr, se;
    wr(4'h0, 32'h703, e); chk("R7 no err", e, 0);
    wait_idle(ok, sr, se); chk("R7 completes", ok, 1);
    chk("R7 enable discarded", {se, core_en_o}, 0);
    rd(4'h0, d); chk("R7 fields discarded", d, 0);
    wr(4'h0, 32'h400, e); rd(4'h4, d); chk("R7 bit0 clear no reset", d[0], 0);
    rd(4'h0, d); chk("R7 normal write", d, 32'h400);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #23 bus_rst_n = 1; core_rst_n = 1;
    t_reset; t_fields; t_enable; t_protect; t_stall;
    t_wp; t_badaddr; t_swrst; t_prio;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule